// File: doc/BRIEF.md
# Inter-Processor Interrupt Trigger Bank

This block is a small register bank on a simple read/write bus. Any master that can reach the bank can use it to send interrupts to other processors in a multicore system. Each interrupt-trigger register has two parts:

- a self-clearing trigger bit, which raises a one-cycle interrupt pulse toward its target processor;
- a field of sticky source-identification flags, which tells the receiver who signalled it.

A flag that is set also shows in a companion acknowledge view. The receiving side clears the flag from that view, either by a bus write or through a dedicated clear port. A second set of registers, one per core, raises one-cycle non-maskable interrupt pulses in the same way.

The bus address is split into two fields:

- The top two bits select a region: trigger registers, acknowledge view, non-maskable trigger registers, or unused.
- The remaining bits select the register index inside that region.

The number of trigger registers and of non-maskable trigger registers are both parameters. Reads are registered and return data one cycle after the address is presented.

Top module: `ipi_regbank`

## Requirements
- R1: A bus write to trigger register i with data bit 0 set drives `ipc_irq[i]` high for exactly the next clock cycle. A write with bit 0 clear produces no pulse.
- R2: In both the trigger registers and the acknowledge view, read data bits 3 down to 0 are always 0, whatever was written to them.
- R3: Each data bit j (4..31) written as 1 to trigger register i sets source flag j-4 of that register. Bits written as 0 leave their flags unchanged. Reading the register returns the stored flags in bits 31 down to 4, one cycle after the address.
- R4: Reading acknowledge-view index i (region 1) returns the same flags as trigger register i, in the same bit positions.
- R5: Writing 1 to data bit j (4..31) of acknowledge-view index i clears flag j-4 of register i. Asserting `ack_clr_en` with `ack_clr_idx`=i clears, in register i, every flag whose bit is set in `ack_clr_mask`.
- R6: When a set and a clear of the same flag are applied in the same cycle, the flag ends up set.
- R7: A bus write with data bit 0 set to non-maskable trigger register c (region 2) drives `nmi_pulse[c]` high for exactly the next cycle. Those registers always read as 0.
- R8: While `rst` is high, all flags, all pulse outputs and `bus_rdata` become 0. Synchronous reset.
- R9: `bus_addr[7:6]` selects the region: 0 = trigger registers, 1 = acknowledge view, 2 = non-maskable trigger registers, 3 = unused. `bus_addr[5:0]` is the index. Writes to region 3 or to an index beyond the parameterised count change nothing, and reads of them return 0.
- R10: `src_flags[i*28 + k]` equals flag k of trigger register i at all times.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_we | input | 1 | Bus write strobe |
| bus_addr | input | ADDR_W (8) | Region and register index |
| bus_wdata | input | DATA_W (32) | Bus write data |
| bus_rdata | output | DATA_W (32) | Registered read data for the previous cycle's address |
| ack_clr_en | input | 1 | Clear-port strobe |
| ack_clr_idx | input | ADDR_W-2 (6) | Register index addressed by the clear port |
| ack_clr_mask | input | DATA_W-4 (28) | Flags to clear, one bit per flag |
| ipc_irq | output | NUM_IPC (5) | One-cycle interrupt pulses, one per trigger register |
| nmi_pulse | output | NUM_NMI (4) | One-cycle non-maskable interrupt pulses, one per core |
| src_flags | output | NUM_IPC*(DATA_W-4) (140) | Source flags of every trigger register, concatenated |

## Verification
The bench uses the default build: five trigger registers, four non-maskable trigger registers and a 6-bit index field. Random indices therefore run from 0 to 7, so writes, reads and port clears regularly land on the three unpopulated trigger indices and the four unpopulated non-maskable indices. Random region values also reach the unused fourth region. Clear-port traffic overlaps random bus writes often enough to produce same-cycle set/clear collisions on shared flags, and directed steps cover that collision explicitly.

// File: rtl/ipi_pkg.sv
package ipi_pkg;
  localparam int REGION_W = 2;
  localparam int TRIG_BIT = 0;
  localparam int FLAG_LSB = 4;

  typedef enum logic [REGION_W-1:0] {
    RG_TRIG = 2'd0,
    RG_ACK  = 2'd1,
    RG_NMI  = 2'd2,
    RG_NONE = 2'd3
  } region_e;
endpackage

// File: rtl/ipi_decode.sv
module ipi_decode
  import ipi_pkg::*;
#(
  parameter int ADDR_W  = 8,
  parameter int NUM_IPC = 5,
  parameter int NUM_NMI = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  output logic [NUM_IPC-1:0] trig_we,
  output logic [NUM_IPC-1:0] ack_we,
  output logic [NUM_NMI-1:0] nmi_we
);
  localparam int IDX_W = ADDR_W - REGION_W;

  region_e          region;
  logic [IDX_W-1:0] idx;

  assign region = region_e'(bus_addr[ADDR_W-1 -: REGION_W]);
  assign idx    = bus_addr[IDX_W-1:0];

  for (genvar i = 0; i < NUM_IPC; i++) begin : g_ipc_dec
    assign trig_we[i] = bus_we && (region == RG_TRIG) && (idx == IDX_W'(i));
    assign ack_we[i]  = bus_we && (region == RG_ACK)  && (idx == IDX_W'(i));
  end

  for (genvar c = 0; c < NUM_NMI; c++) begin : g_nmi_dec
    assign nmi_we[c] = bus_we && (region == RG_NMI) && (idx == IDX_W'(c));
  end

  // R9: one bus write reaches at most one register
  a_r9_single_target: assert property (@(posedge clk) disable iff (rst)
    $onehot0({trig_we, ack_we, nmi_we}));

  // R9: region 3 never produces a write strobe
  a_r9_unused_region: assert property (@(posedge clk) disable iff (rst)
    (bus_addr[ADDR_W-1 -: REGION_W] == 2'd3) |-> ({trig_we, ack_we, nmi_we} == '0));
endmodule

// File: rtl/ipi_ipc_slot.sv
module ipi_ipc_slot #(
  parameter int SRC_W = 28
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             trig_we,
  input  logic             trig_bit,
  input  logic [SRC_W-1:0] set_bits,
  input  logic [SRC_W-1:0] clr_bits,
  output logic [SRC_W-1:0] flags,
  output logic             irq
);
  logic [SRC_W-1:0] set_eff;

  assign set_eff = trig_we ? set_bits : '0;

  always_ff @(posedge clk) begin
    if (rst) begin
      flags <= '0;
      irq   <= 1'b0;
    end else begin
      flags <= (flags & ~clr_bits) | set_eff;
      irq   <= trig_we & trig_bit;
    end
  end

  // R1: a pulse only follows a trigger write with bit 0 set
  a_r1_pulse_cause: assert property (@(posedge clk) disable iff (rst)
    irq |-> $past(trig_we && trig_bit));

  // R1: without a new trigger, the pulse drops after one cycle
  a_r1_single_cycle: assert property (@(posedge clk) disable iff (rst)
    (irq && !(trig_we && trig_bit)) |=> !irq);

  // R3, R6: written ones are present on the next cycle, even against a clear
  a_r6_set_wins: assert property (@(posedge clk) disable iff (rst)
    trig_we |=> ((flags & $past(set_bits)) == $past(set_bits)));

  // R5: cleared bits that were not set in the same cycle are gone
  a_r5_clear_takes: assert property (@(posedge clk) disable iff (rst)
    (|clr_bits) |=> ((flags & $past(clr_bits & ~set_eff)) == '0));

  // R3: flags hold without any set or clear
  a_r3_flags_hold: assert property (@(posedge clk) disable iff (rst)
    (!trig_we && (clr_bits == '0)) |=> $stable(flags));
endmodule

// File: rtl/ipi_nmi_gen.sv
module ipi_nmi_gen #(
  parameter int NUM_NMI = 4
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_NMI-1:0] nmi_we,
  input  logic               trig_bit,
  output logic [NUM_NMI-1:0] nmi_pulse
);
  always_ff @(posedge clk) begin
    if (rst) nmi_pulse <= '0;
    else     nmi_pulse <= trig_bit ? nmi_we : '0;
  end

  for (genvar c = 0; c < NUM_NMI; c++) begin : g_chk
    // R7: pulse only after a write of 1 to that core's register
    a_r7_nmi_cause: assert property (@(posedge clk) disable iff (rst)
      nmi_pulse[c] |-> $past(nmi_we[c] && trig_bit));
    // R7: at most one cycle per accepted write
    a_r7_nmi_single: assert property (@(posedge clk) disable iff (rst)
      (nmi_pulse[c] && !(nmi_we[c] && trig_bit)) |=> !nmi_pulse[c]);
  end
endmodule

// File: rtl/ipi_regbank.sv
module ipi_regbank
  import ipi_pkg::*;
#(
  parameter int  ADDR_W  = 8,
  parameter int  DATA_W  = 32,
  parameter int  NUM_IPC = 5,
  parameter int  NUM_NMI = 4,
  localparam int IDX_W   = ADDR_W - REGION_W,
  localparam int SRC_W   = DATA_W - FLAG_LSB
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     bus_we,
  input  logic [ADDR_W-1:0]        bus_addr,
  input  logic [DATA_W-1:0]        bus_wdata,
  output logic [DATA_W-1:0]        bus_rdata,
  input  logic                     ack_clr_en,
  input  logic [IDX_W-1:0]         ack_clr_idx,
  input  logic [SRC_W-1:0]         ack_clr_mask,
  output logic [NUM_IPC-1:0]       ipc_irq,
  output logic [NUM_NMI-1:0]       nmi_pulse,
  output logic [NUM_IPC*SRC_W-1:0] src_flags
);
  logic [NUM_IPC-1:0] trig_we;
  logic [NUM_IPC-1:0] ack_we;
  logic [NUM_NMI-1:0] nmi_we;
  logic [SRC_W-1:0]   wr_flags;
  logic [SRC_W-1:0]   flags_arr [NUM_IPC];
  logic [DATA_W-1:0]  rd_next;
  region_e            rd_region;
  logic [IDX_W-1:0]   rd_idx;

  assign wr_flags = bus_wdata[DATA_W-1:FLAG_LSB];

  ipi_decode #(
    .ADDR_W (ADDR_W),
    .NUM_IPC(NUM_IPC),
    .NUM_NMI(NUM_NMI)
  ) u_decode (
    .clk     (clk),
    .rst     (rst),
    .bus_we  (bus_we),
    .bus_addr(bus_addr),
    .trig_we (trig_we),
    .ack_we  (ack_we),
    .nmi_we  (nmi_we)
  );

  for (genvar i = 0; i < NUM_IPC; i++) begin : g_slot
    logic [SRC_W-1:0] clr_bits;

    assign clr_bits = (ack_we[i] ? wr_flags : '0)
                    | ((ack_clr_en && (ack_clr_idx == IDX_W'(i))) ? ack_clr_mask : '0);

    ipi_ipc_slot #(
      .SRC_W(SRC_W)
    ) u_slot (
      .clk     (clk),
      .rst     (rst),
      .trig_we (trig_we[i]),
      .trig_bit(bus_wdata[TRIG_BIT]),
      .set_bits(wr_flags),
      .clr_bits(clr_bits),
      .flags   (flags_arr[i]),
      .irq     (ipc_irq[i])
    );

    assign src_flags[i*SRC_W +: SRC_W] = flags_arr[i];
  end

  ipi_nmi_gen #(
    .NUM_NMI(NUM_NMI)
  ) u_nmi (
    .clk      (clk),
    .rst      (rst),
    .nmi_we   (nmi_we),
    .trig_bit (bus_wdata[TRIG_BIT]),
    .nmi_pulse(nmi_pulse)
  );

  assign rd_region = region_e'(bus_addr[ADDR_W-1 -: REGION_W]);
  assign rd_idx    = bus_addr[IDX_W-1:0];

  always_comb begin
    rd_next = '0;
    if (rd_region == RG_TRIG || rd_region == RG_ACK) begin
      for (int k = 0; k < NUM_IPC; k++) begin
        if (rd_idx == IDX_W'(k)) rd_next = {flags_arr[k], {FLAG_LSB{1'b0}}};
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) bus_rdata <= '0;
    else     bus_rdata <= rd_next;
  end

  // R2: trigger and reserved positions never read back as 1
  a_r2_low_bits_zero: assert property (@(posedge clk) disable iff (rst)
    bus_rdata[FLAG_LSB-1:0] == '0);

  // R7, R9: the non-maskable region and the unused region read as zero
  a_r9_dead_regions_read_zero: assert property (@(posedge clk) disable iff (rst)
    (bus_addr[ADDR_W-1] == 1'b1) |=> (bus_rdata == '0));
endmodule

// File: tb/ipi_regbank_bench.sv
module ipi_regbank_bench;
  localparam int ADDR_W  = 8;
  localparam int DATA_W  = 32;
  localparam int NUM_IPC = 5;
  localparam int NUM_NMI = 4;
  localparam int IDX_W   = ADDR_W - 2;
  localparam int SRC_W   = DATA_W - 4;
  localparam int VW      = 160;

  logic                     clk = 1'b0;
  logic                     rst = 1'b1;
  logic                     bus_we = 1'b0;
  logic [ADDR_W-1:0]        bus_addr = '0;
  logic [DATA_W-1:0]        bus_wdata = '0;
  logic [DATA_W-1:0]        bus_rdata;
  logic                     ack_clr_en = 1'b0;
  logic [IDX_W-1:0]         ack_clr_idx = '0;
  logic [SRC_W-1:0]         ack_clr_mask = '0;
  logic [NUM_IPC-1:0]       ipc_irq;
  logic [NUM_NMI-1:0]       nmi_pulse;
  logic [NUM_IPC*SRC_W-1:0] src_flags;

  int checks = 0;
  int failures = 0;
  logic [SRC_W-1:0] m_flags [NUM_IPC];

  always #5 clk = ~clk;

  ipi_regbank #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W),
    .NUM_IPC(NUM_IPC),
    .NUM_NMI(NUM_NMI)
  ) u_ipi_regbank (
    .clk         (clk),
    .rst         (rst),
    .bus_we      (bus_we),
    .bus_addr    (bus_addr),
    .bus_wdata   (bus_wdata),
    .bus_rdata   (bus_rdata),
    .ack_clr_en  (ack_clr_en),
    .ack_clr_idx (ack_clr_idx),
    .ack_clr_mask(ack_clr_mask),
    .ipc_irq     (ipc_irq),
    .nmi_pulse   (nmi_pulse),
    .src_flags   (src_flags)
  );

  task automatic chk(string tag, logic [VW-1:0] act, logic [VW-1:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [ADDR_W-1:0] adr(int region, int idx);
    return {region[1:0], idx[IDX_W-1:0]};
  endfunction

  function automatic logic [DATA_W-1:0] exp_read(logic [ADDR_W-1:0] a);
    int rg = int'(a[7:6]);
    int ix = int'(a[5:0]);
    if ((rg == 0 || rg == 1) && ix < NUM_IPC) return {m_flags[ix], 4'b0000};
    return '0;
  endfunction

  function automatic logic [NUM_IPC*SRC_W-1:0] exp_vec();
    logic [NUM_IPC*SRC_W-1:0] v;
    for (int i = 0; i < NUM_IPC; i++) v[i*SRC_W +: SRC_W] = m_flags[i];
    return v;
  endfunction

  // One clock step: drive at the falling edge, check just after the rising edge
  task automatic step(logic we, logic [ADDR_W-1:0] a, logic [DATA_W-1:0] d,
                      logic cen, logic [IDX_W-1:0] cidx, logic [SRC_W-1:0] cmask,
                      string rtag);
    logic [NUM_IPC-1:0] e_irq = '0;
    logic [NUM_NMI-1:0] e_nmi = '0;
    logic [DATA_W-1:0]  e_rd;
    int rg = int'(a[7:6]);
    int ix = int'(a[5:0]);
    @(negedge clk);
    bus_we = we; bus_addr = a; bus_wdata = d;
    ack_clr_en = cen; ack_clr_idx = cidx; ack_clr_mask = cmask;
    e_rd = exp_read(a);
    if (we && d[0] && rg == 0 && ix < NUM_IPC) e_irq[ix] = 1'b1;
    if (we && d[0] && rg == 2 && ix < NUM_NMI) e_nmi[ix] = 1'b1;
    for (int i = 0; i < NUM_IPC; i++) begin
      logic [SRC_W-1:0] s = '0;
      logic [SRC_W-1:0] c = '0;
      if (we && rg == 0 && ix == i) s = d[31:4];
      if (we && rg == 1 && ix == i) c = d[31:4];
      if (cen && int'(cidx) == i) c = c | cmask;
      m_flags[i] = (m_flags[i] & ~c) | s;
    end
    @(posedge clk);
    #1;
    chk("R1 ipc_irq", VW'(ipc_irq), VW'(e_irq));
    chk("R7 nmi_pulse", VW'(nmi_pulse), VW'(e_nmi));
    chk("R10 src_flags", VW'(src_flags), VW'(exp_vec()));
    chk({rtag, " bus_rdata"}, VW'(bus_rdata), VW'(e_rd));
  endtask

  task automatic rd(int region, int idx, string tag);
    step(1'b0, adr(region, idx), '0, 1'b0, '0, '0, tag);
  endtask

  task automatic wr(int region, int idx, logic [DATA_W-1:0] d, string tag);
    step(1'b1, adr(region, idx), d, 1'b0, '0, '0, tag);
  endtask

  initial begin
    #2_000_000;
    failures++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    for (int i = 0; i < NUM_IPC; i++) m_flags[i] = '0;
    // Load the flags with ones while reset is high to show that reset clears them
    repeat (2) @(negedge clk);
    bus_we = 1'b1; bus_addr = adr(0, 1); bus_wdata = 32'hFFFF_FFF1;
    @(negedge clk);
    bus_we = 1'b0;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    @(posedge clk); #1;
    // R8: reset state
    chk("R8 rdata", VW'(bus_rdata), '0);
    chk("R8 ipc_irq", VW'(ipc_irq), '0);
    chk("R8 nmi_pulse", VW'(nmi_pulse), '0);
    chk("R8 src_flags", VW'(src_flags), '0);
    rd(0, 1, "R8");

    // R1: trigger pulse, then idle, then write of 0
    wr(0, 2, 32'h0000_0001, "R1");
    rd(0, 2, "R1");
    wr(0, 2, 32'h0000_0000, "R1");
    // R2/R3: set flags together with the reserved bits
    wr(0, 1, 32'hA000_005E, "R2");
    wr(0, 1, 32'h0000_0010, "R3");
    rd(0, 1, "R3");
    // R4: the acknowledge view mirrors the flags
    rd(1, 1, "R4");
    // R5: clear through a bus write to the acknowledge view and through the port
    wr(1, 1, 32'h8000_0000, "R5");
    rd(0, 1, "R5");
    step(1'b0, adr(0, 1), '0, 1'b1, 6'd1, 28'h000_0001, "R5");
    rd(1, 1, "R5");
    // R6: a set collides with a clear of all flags on the same register
    wr(0, 3, 32'h0000_0300, "R6");
    step(1'b1, adr(0, 3), 32'h0000_0101, 1'b1, 6'd3, 28'hFFF_FFFF, "R6");
    rd(0, 3, "R6");
    // R7: non-maskable pulse, and its register reads as 0
    wr(2, 3, 32'hFFFF_FFFF, "R7");
    rd(2, 3, "R7");
    wr(2, 0, 32'h0000_0000, "R7");
    // R9: index beyond the count, unused region, port clear of a missing index
    wr(0, 6, 32'hFFFF_FFFF, "R9");
    wr(3, 0, 32'hFFFF_FFFF, "R9");
    wr(2, 5, 32'h0000_0001, "R9");
    rd(3, 0, "R9");
    rd(0, 6, "R9");
    step(1'b0, adr(0, 0), '0, 1'b1, 6'd7, 28'hFFF_FFFF, "R9");

    // Random traffic, checked by the same model (R3 tags the read check)
    for (int n = 0; n < 3000; n++) begin
      logic we = ($urandom % 3) != 0;
      int rg = int'($urandom % 4);
      int ix = int'($urandom % 8);
      logic [DATA_W-1:0] d = $urandom;
      logic cen = ($urandom % 4) == 0;
      logic [IDX_W-1:0] ci = IDX_W'($urandom % 8);
      logic [SRC_W-1:0] cm = SRC_W'($urandom);
      if (($urandom % 3) == 0) d = d & 32'h0000_0011;
      step(we, adr(rg, ix), d, cen, ci, cm, "R3");
    end

    step(1'b0, adr(0, 0), '0, 1'b0, '0, '0, "R3");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule